// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a memory reference into a 32-bit linear address by adding the base address of one of six segments to an effective offset. The offset is the sum of an optional base register value, an optional index register value and a displacement. For an instruction fetch the offset is the instruction pointer instead. The six segment bases sit in a small register file that is loaded through a dedicated write port.

The segment is chosen from the kind of access and the base register named. Fetches always use the code segment. Stack accesses use the stack segment, and so does any data address whose base register is the frame pointer. All other accesses use the default data segment. For any access other than a fetch, an explicit override input can name any of the six segments.

For string accesses the block also returns the pointer advanced by one element. The element is 1, 2 or 4 bytes. The pointer moves down when the direction bit of the flags word is set and up when it is clear. Results are registered, and they appear one cycle after the request together with a valid strobe.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is held, and until the first request, `addr_valid` is 0 and `lin_addr`, `seg_used` and `ptr_next` are 0. All six segment bases reset to 0.
- R2: When `wr_en` is high and `wr_seg` is 0 to 5, the base of that segment is loaded at the clock edge. A request in the same cycle still sees the old base, and requests from the next cycle on see the new one. When `wr_seg` is 6 or 7 the write is ignored.
- R3: `addr_valid` is high in exactly the cycle after a cycle with `req_valid` high. When no request is made, `lin_addr`, `seg_used` and `ptr_next` hold their values.
- R4: For kinds other than fetch, the offset is `base_val` (if `base_en`) plus `idx_val` (if `idx_en`) plus `disp`. The linear address is the segment base plus that offset. All sums wrap modulo 2^32.
- R5: A fetch (`req_kind` = 2) uses segment CS and takes `ip_val` as the offset. Any override is ignored.
- R6: A stack access (`req_kind` = 1) without an override uses SS.
- R7: A data (`req_kind` = 0) or string (`req_kind` = 3) access without an override uses SS when `base_en` is set and `base_reg` is 5 (the frame pointer). Otherwise it uses DS.
- R8: For non-fetch kinds, `ovr_en` with `ovr_seg` from 0 to 5 selects that segment. An override code of 6 or 7 is ignored and the default applies.
- R9: For a string access, `ptr_next` is `base_val` minus the step when bit 10 of `flags` is set, and `base_val` plus the step when it is clear, modulo 2^32. For other kinds `ptr_next` equals `base_val`.
- R10: The step is 1 byte for `str_size` 0, 2 bytes for 1, and 4 bytes for 2 or 3.
- R11: `seg_used` reports the code of the segment applied: ES=0, CS=1, SS=2, DS=3, FS=4, GS=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Segment base write strobe |
| wr_seg | input | 3 | Segment code to write |
| wr_base | input | 32 | New base address |
| req_valid | input | 1 | Address request |
| req_kind | input | 2 | 0 data, 1 stack, 2 fetch, 3 string |
| ovr_en | input | 1 | Segment override present |
| ovr_seg | input | 3 | Override segment code |
| base_en | input | 1 | Base register used |
| base_reg | input | 3 | Base register number (5 = frame pointer) |
| base_val | input | 32 | Base register value / string pointer |
| idx_en | input | 1 | Index register used |
| idx_val | input | 32 | Index register value |
| disp | input | 32 | Displacement |
| ip_val | input | 32 | Instruction pointer for fetches |
| flags | input | 32 | Flags word; bit 10 is direction |
| str_size | input | 2 | String element size code |
| addr_valid | output | 1 | Result valid strobe |
| lin_addr | output | 32 | Linear address |
| seg_used | output | 3 | Segment code applied |
| ptr_next | output | 32 | Stepped string pointer |

## Verification
The assertions assume that `req_valid` stays low while reset is held. They also assume that every input is settled one clock before the edge that captures it, because their `$past` terms compare outputs with the inputs of the previous cycle. The stimulus drives all inputs on the falling edge, keeps the request low through reset, and drops it between requests so that idle hold behaviour is observed. Segment writes are issued on their own or deliberately beside a request, which exercises the same-cycle ordering.

// File: rtl/seg_agen_pkg.sv
package seg_agen_pkg;
   typedef enum logic [1:0] {
      K_DATA   = 2'd0,
      K_STACK  = 2'd1,
      K_FETCH  = 2'd2,
      K_STRING = 2'd3
   } acc_kind_e;

   localparam int SEG_W = 3;
   localparam logic [SEG_W-1:0] SEG_ES = 3'd0;
   localparam logic [SEG_W-1:0] SEG_CS = 3'd1;
   localparam logic [SEG_W-1:0] SEG_SS = 3'd2;
   localparam logic [SEG_W-1:0] SEG_DS = 3'd3;
   localparam logic [SEG_W-1:0] SEG_FS = 3'd4;
   localparam logic [SEG_W-1:0] SEG_GS = 3'd5;
endpackage

// File: rtl/seg_base_file.sv
module seg_base_file #(
   parameter int AW   = 32,
   parameter int NSEG = 6,
   parameter int SW   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [SW-1:0] wr_sel,
   input  logic [AW-1:0] wr_data,
   input  logic [SW-1:0] rd_sel,
   output logic [AW-1:0] rd_base
);
   localparam logic [SW:0] LIM = (SW+1)'(NSEG);

   generate
      if (NSEG < 6 || NSEG >= (1 << SW)) begin : g_bad_nseg
         $error("seg_base_file: NSEG must be at least 6 and below 2**SW");
      end
      if (AW < 8) begin : g_bad_aw
         $error("seg_base_file: AW too small");
      end
   endgenerate

   logic [AW-1:0]   base_q [NSEG];
   logic [NSEG-1:0] wen;

   generate
      for (genvar g = 0; g < NSEG; g++) begin : g_seg
         assign wen[g] = wr_en && (wr_sel == SW'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      base_q[g] <= '0;
            else if (wen[g]) base_q[g] <= wr_data;
         end
      end
   endgenerate

   always_comb begin
      rd_base = '0;
      for (int i = 0; i < NSEG; i++) begin
         if (rd_sel == SW'(i)) rd_base = base_q[i];
      end
   end

   assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wen));

   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ({1'b0, wr_sel} < LIM)) |=> (base_q[$past(wr_sel)] == $past(wr_data)));
endmodule

// File: rtl/seg_select.sv
module seg_select
   import seg_agen_pkg::*;
#(
   parameter int SW      = 3,
   parameter int RW      = 3,
   parameter int NSEG    = 6,
   parameter int FP_CODE = 5
) (
   input  logic [1:0]    kind,
   input  logic          ovr_en,
   input  logic [SW-1:0] ovr_seg,
   input  logic          base_en,
   input  logic [RW-1:0] base_reg,
   output logic [SW-1:0] seg
);
   localparam logic [SW:0]   LIM = (SW+1)'(NSEG);
   localparam logic [RW-1:0] FP  = RW'(FP_CODE);

   generate
      if (FP_CODE >= (1 << RW)) begin : g_bad_fp
         $error("seg_select: FP_CODE does not fit in RW bits");
      end
   endgenerate

   acc_kind_e k;
   logic      ovr_ok;

   assign k      = acc_kind_e'(kind);
   assign ovr_ok = ovr_en && ({1'b0, ovr_seg} < LIM);

   always_comb begin
      if (k == K_FETCH)                seg = SEG_CS;
      else if (ovr_ok)                 seg = ovr_seg;
      else if (k == K_STACK)           seg = SEG_SS;
      else if (base_en && base_reg == FP) seg = SEG_SS;
      else                             seg = SEG_DS;
   end
endmodule

// File: rtl/off_calc.sv
module off_calc
   import seg_agen_pkg::*;
#(
   parameter int AW     = 32,
   parameter int FW     = 32,
   parameter int DF_BIT = 10
) (
   input  logic [1:0]    kind,
   input  logic          base_en,
   input  logic [AW-1:0] base_val,
   input  logic          idx_en,
   input  logic [AW-1:0] idx_val,
   input  logic [AW-1:0] disp,
   input  logic [AW-1:0] ip_val,
   input  logic [FW-1:0] flags,
   input  logic [1:0]    size,
   output logic [AW-1:0] eff_off,
   output logic [AW-1:0] ptr_next
);
   generate
      if (DF_BIT >= FW) begin : g_bad_df
         $error("off_calc: DF_BIT outside flags word");
      end
   endgenerate

   acc_kind_e     k;
   logic [AW-1:0] b_term, i_term, step;
   logic          down;

   assign k      = acc_kind_e'(kind);
   assign b_term = base_en ? base_val : '0;
   assign i_term = idx_en  ? idx_val  : '0;
   assign down   = flags[DF_BIT];

   always_comb begin
      case (size)
         2'd0:    step = AW'(1);
         2'd1:    step = AW'(2);
         default: step = AW'(4);
      endcase
   end

   always_comb begin
      if (k == K_FETCH) eff_off = ip_val;
      else              eff_off = b_term + i_term + disp;
   end

   always_comb begin
      if (k != K_STRING) ptr_next = base_val;
      else if (down)     ptr_next = base_val - step;
      else               ptr_next = base_val + step;
   end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_agen_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NSEG    = 6,
   parameter int SW      = 3,
   parameter int RW      = 3,
   parameter int FW      = 32,
   parameter int DF_BIT  = 10,
   parameter int FP_CODE = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [SW-1:0] wr_seg,
   input  logic [AW-1:0] wr_base,
   input  logic          req_valid,
   input  logic [1:0]    req_kind,
   input  logic          ovr_en,
   input  logic [SW-1:0] ovr_seg,
   input  logic          base_en,
   input  logic [RW-1:0] base_reg,
   input  logic [AW-1:0] base_val,
   input  logic          idx_en,
   input  logic [AW-1:0] idx_val,
   input  logic [AW-1:0] disp,
   input  logic [AW-1:0] ip_val,
   input  logic [FW-1:0] flags,
   input  logic [1:0]    str_size,
   output logic          addr_valid,
   output logic [AW-1:0] lin_addr,
   output logic [SW-1:0] seg_used,
   output logic [AW-1:0] ptr_next
);
   localparam logic [SW:0]   LIM = (SW+1)'(NSEG);
   localparam logic [RW-1:0] FP  = RW'(FP_CODE);

   logic [SW-1:0] seg_sel;
   logic [AW-1:0] seg_base, eff_off, ptr_c, lin_c;

   seg_base_file #(.AW(AW), .NSEG(NSEG), .SW(SW)) u_bases (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_seg),
      .wr_data (wr_base),
      .rd_sel  (seg_sel),
      .rd_base (seg_base)
   );

   seg_select #(.SW(SW), .RW(RW), .NSEG(NSEG), .FP_CODE(FP_CODE)) u_sel (
      .kind     (req_kind),
      .ovr_en   (ovr_en),
      .ovr_seg  (ovr_seg),
      .base_en  (base_en),
      .base_reg (base_reg),
      .seg      (seg_sel)
   );

   off_calc #(.AW(AW), .FW(FW), .DF_BIT(DF_BIT)) u_off (
      .kind     (req_kind),
      .base_en  (base_en),
      .base_val (base_val),
      .idx_en   (idx_en),
      .idx_val  (idx_val),
      .disp     (disp),
      .ip_val   (ip_val),
      .flags    (flags),
      .size     (str_size),
      .eff_off  (eff_off),
      .ptr_next (ptr_c)
   );

   assign lin_c = seg_base + eff_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_valid <= 1'b0;
         lin_addr   <= '0;
         seg_used   <= '0;
         ptr_next   <= '0;
      end else begin
         addr_valid <= req_valid;
         if (req_valid) begin
            lin_addr <= lin_c;
            seg_used <= seg_sel;
            ptr_next <= ptr_c;
         end
      end
   end

   assert_valid_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> addr_valid);

   assert_valid_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !addr_valid);

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(lin_addr) && $stable(seg_used) && $stable(ptr_next)));

   assert_fetch_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd2) |=> (seg_used == SEG_CS));

   assert_fetch_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd2) |=> (lin_addr == $past(seg_base) + $past(ip_val)));

   assert_stack_ss_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd1 && !(ovr_en && {1'b0, ovr_seg} < LIM))
      |=> (seg_used == SEG_SS));

   assert_frame_ss_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != 2'd2 && base_en && base_reg == FP
       && !(ovr_en && {1'b0, ovr_seg} < LIM)) |=> (seg_used == SEG_SS));

   assert_override_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != 2'd2 && ovr_en && {1'b0, ovr_seg} < LIM)
      |=> (seg_used == $past(ovr_seg)));

   assert_step_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd3 && !flags[DF_BIT])
      |=> ((ptr_next - $past(base_val)) inside {AW'(1), AW'(2), AW'(4)}));

   assert_step_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == 2'd3 && flags[DF_BIT])
      |=> (($past(base_val) - ptr_next) inside {AW'(1), AW'(2), AW'(4)}));

   assert_seg_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> ({1'b0, seg_used} < LIM));
endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_seg = '0;
   logic [31:0] wr_base = '0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = '0;
   logic        ovr_en = 1'b0;
   logic [2:0]  ovr_seg = '0;
   logic        base_en = 1'b0;
   logic [2:0]  base_reg = '0;
   logic [31:0] base_val = '0;
   logic        idx_en = 1'b0;
   logic [31:0] idx_val = '0;
   logic [31:0] disp = '0;
   logic [31:0] ip_val = '0;
   logic [31:0] flags = '0;
   logic [1:0]  str_size = '0;
   logic        addr_valid;
   logic [31:0] lin_addr;
   logic [2:0]  seg_used;
   logic [31:0] ptr_next;

   int checks = 0;
   int fails  = 0;
   logic [31:0] mdl_base [6];

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_seg(wr_seg), .wr_base(wr_base),
      .req_valid(req_valid), .req_kind(req_kind), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
      .base_en(base_en), .base_reg(base_reg), .base_val(base_val), .idx_en(idx_en),
      .idx_val(idx_val), .disp(disp), .ip_val(ip_val), .flags(flags),
      .str_size(str_size), .addr_valid(addr_valid), .lin_addr(lin_addr),
      .seg_used(seg_used), .ptr_next(ptr_next)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_seg(input logic [1:0] k, input logic oe,
                                         input logic [2:0] os, input logic be,
                                         input logic [2:0] br);
      if (k == 2'd2) return 3'd1;
      if (oe && os <= 3'd5) return os;
      if (k == 2'd1) return 3'd2;
      if (be && br == 3'd5) return 3'd2;
      return 3'd3;
   endfunction

   task automatic write_base(input logic [2:0] s, input logic [31:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_seg = s; wr_base = v;
      @(negedge clk);
      wr_en = 1'b0;
      if (s <= 3'd5) mdl_base[s] = v;
   endtask

   // Issues one request and checks all outputs one cycle later.
   task automatic do_req(input string req, input logic [1:0] k, input logic oe,
                         input logic [2:0] os, input logic be, input logic [2:0] br,
                         input logic [31:0] bv, input logic ie, input logic [31:0] iv,
                         input logic [31:0] d, input logic [31:0] ip,
                         input logic [31:0] fl, input logic [1:0] sz);
      logic [2:0]  es;
      logic [31:0] off, stp, ep;
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; ovr_en = oe; ovr_seg = os; base_en = be;
      base_reg = br; base_val = bv; idx_en = ie; idx_val = iv; disp = d;
      ip_val = ip; flags = fl; str_size = sz;
      es  = exp_seg(k, oe, os, be, br);
      off = (k == 2'd2) ? ip : ((be ? bv : 32'd0) + (ie ? iv : 32'd0) + d);
      stp = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
      ep  = (k != 2'd3) ? bv : (fl[10] ? bv - stp : bv + stp);
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " valid"}, {31'd0, addr_valid}, 32'd1);
      check({req, " seg"}, {29'd0, seg_used}, {29'd0, es});
      check({req, " addr"}, lin_addr, mdl_base[es] + off);
      check({req, " ptr"}, ptr_next, ep);
   endtask

   task automatic t_reset();
      check("R1 valid", {31'd0, addr_valid}, 32'd0);
      check("R1 addr", lin_addr, 32'd0);
      check("R1 seg", {29'd0, seg_used}, 32'd0);
      check("R1 ptr", ptr_next, 32'd0);
   endtask

   task automatic t_writes();
      write_base(3'd0, 32'h1000_0000);
      write_base(3'd1, 32'h0001_0000);
      write_base(3'd2, 32'h0002_0000);
      write_base(3'd3, 32'h0003_0000);
      write_base(3'd4, 32'h0004_0000);
      write_base(3'd5, 32'h8000_0000);
      write_base(3'd6, 32'hDEAD_BEEF);
      write_base(3'd7, 32'hDEAD_BEEF);
      for (int s = 0; s < 6; s++)
         do_req("R2 R8 readback", 2'd0, 1'b1, 3'(s), 1'b0, 3'd0, 32'd0, 1'b0, 32'd0,
                32'h10, 32'd0, 32'd0, 2'd0);
   endtask

   task automatic t_hold();
      logic [31:0] last;
      last = lin_addr;
      @(negedge clk);
      check("R3 idle valid", {31'd0, addr_valid}, 32'd0);
      check("R3 idle hold", lin_addr, last);
   endtask

   task automatic t_kinds();
      do_req("R5 fetch", 2'd2, 1'b1, 3'd5, 1'b1, 3'd5, 32'h55, 1'b1, 32'h66,
             32'h77, 32'h0000_1234, 32'd0, 2'd0);
      do_req("R6 stack", 2'd1, 1'b0, 3'd0, 1'b1, 3'd4, 32'h0000_FFF0, 1'b0, 32'd0,
             32'hFFFF_FFFC, 32'd0, 32'd0, 2'd0);
      do_req("R7 frame", 2'd0, 1'b0, 3'd0, 1'b1, 3'd5, 32'h0000_0100, 1'b0, 32'd0,
             32'h8, 32'd0, 32'd0, 2'd0);
      do_req("R7 R4 data", 2'd0, 1'b0, 3'd0, 1'b1, 3'd3, 32'h0000_0100, 1'b1, 32'h20,
             32'h8, 32'd0, 32'd0, 2'd0);
      do_req("R7 idx only", 2'd0, 1'b0, 3'd0, 1'b0, 3'd5, 32'hFFFF, 1'b1, 32'h40,
             32'h4, 32'd0, 32'd0, 2'd0);
      do_req("R8 frame ovr", 2'd0, 1'b1, 3'd4, 1'b1, 3'd5, 32'h100, 1'b0, 32'd0,
             32'd0, 32'd0, 32'd0, 2'd0);
      do_req("R8 bad ovr", 2'd1, 1'b1, 3'd6, 1'b0, 3'd0, 32'h100, 1'b0, 32'd0,
             32'd0, 32'd0, 32'd0, 2'd0);
      do_req("R4 wrap", 2'd0, 1'b1, 3'd5, 1'b1, 3'd0, 32'h9000_0000, 1'b1, 32'h1,
             32'hFFFF_FFFF, 32'd0, 32'd0, 2'd0);
   endtask

   task automatic t_string();
      do_req("R9 R10 up1", 2'd3, 1'b0, 3'd0, 1'b1, 3'd6, 32'h200, 1'b0, 32'd0,
             32'd0, 32'd0, 32'd0, 2'd0);
      do_req("R9 R10 up2", 2'd3, 1'b0, 3'd0, 1'b1, 3'd6, 32'h200, 1'b0, 32'd0,
             32'd0, 32'd0, 32'd0, 2'd1);
      do_req("R9 R10 dn4", 2'd3, 1'b0, 3'd0, 1'b1, 3'd7, 32'h200, 1'b0, 32'd0,
             32'd0, 32'd0, 32'h0000_0400, 2'd2);
      do_req("R9 R10 dn4c3", 2'd3, 1'b1, 3'd0, 1'b1, 3'd7, 32'h2, 1'b0, 32'd0,
             32'd0, 32'd0, 32'hFFFF_FFFF, 2'd3);
      do_req("R9 up wrap", 2'd3, 1'b0, 3'd0, 1'b1, 3'd6, 32'hFFFF_FFFF, 1'b0, 32'd0,
             32'd0, 32'd0, 32'hFFFF_FBFF, 2'd0);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      wr_en = 1'b1; wr_seg = 3'd3; wr_base = 32'h0ABC_0000;
      req_valid = 1'b1; req_kind = 2'd0; ovr_en = 1'b0; base_en = 1'b0;
      idx_en = 1'b0; disp = 32'h5;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      check("R2 old base same cycle", lin_addr, mdl_base[3] + 32'h5);
      mdl_base[3] = 32'h0ABC_0000;
      do_req("R2 new base", 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 32'd0, 1'b0, 32'd0,
             32'h5, 32'd0, 32'd0, 2'd0);
   endtask

   initial begin
      for (int s = 0; s < 6; s++) mdl_base[s] = '0;
      #(CLK_PERIOD * 3 + 1);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_writes();
      t_hold();
      t_kinds();
      t_string();
      t_same_cycle();
      t_hold();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule